// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a synchronous request/acknowledge port and an external asynchronous 16-bit static RAM. A requester presents an address, write data, two byte-lane enables and a read/write command. The controller accepts the request when it is ready. It then drives the active-low chip select, write strobe, output enable and byte-lane selects through a fixed state sequence: idle, setup, strobe, recovery, idle. It also controls the direction of the shared data bus, which is modelled as separate in, out and drive-enable signals.

Every interval the SRAM needs is a parameter in picoseconds. The controller turns each one into a count of system clocks, rounding up and never going below one. A read takes a strobe long enough for address access, cycle time and output-enable access. A write takes a strobe long enough for pulse width, chip-select overlap, address setup, cycle time, and the bus turnaround gap followed by data setup. After reset, a power-up lockout keeps the port closed until the required wait has passed. Read data is masked to the enabled lanes and returned with a single-cycle valid pulse.

Top module: `sram_access_ctrl`

## Requirements
- R1: After reset release, `req_ready_o` stays low, and no SRAM select goes low, for exactly PWR_CYC = max(1, ceil(T_PWRUP_PS / CLK_PS)) clock edges. A request held during that time is not accepted.
- R2: While reset is asserted, `sram_ce_no`, `sram_we_no` and `sram_oe_no` are 1, `sram_be_no` is 2'b11, and `sram_dq_oe_o` and `rd_valid_o` are 0.
- R3: A read holds `sram_oe_no` low for exactly RD_CYC clock cycles. RD_CYC is the largest of the rounded-up counts for cycle time, address access and output-enable access. Each count is ceil(t / CLK_PS), with a minimum of 1.
- R4: A write holds `sram_we_no` low for exactly WP_CYC cycles. WP_CYC is the largest of: the write cycle count, the pulse width count, the select-overlap count, the address-setup count, and the turnaround count plus the data-setup count. `sram_we_no` is never low while `sram_ce_no` is high.
- R5: `sram_dq_oe_o` stays low for the first HZ_CYC = ceil(T_HZWE_PS / CLK_PS) cycles of the write strobe. It is high for the rest of the strobe and for the recovery cycle. It is never high while `sram_oe_no` is low.
- R6: A write updates only the lanes whose bit in `req_be_i` is 1. Bit 0 selects data bits 7:0 and bit 1 selects bits 15:8. An enabled lane drives its `sram_be_no` bit to 0 during setup and strobe.
- R7: A read raises `rd_valid_o` for exactly one cycle, in the cycle after the strobe ends. `rd_data_o` then holds the bus value sampled on the last strobe cycle, with disabled lanes forced to zero.
- R8: `req_ready_o` is high only in idle, after power-up. An accepted read keeps it low for RD_CYC+2 cycles, and an accepted write keeps it low for WP_CYC+2 cycles.
- R9: `sram_addr_o` does not change while `sram_ce_no` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Controller can take a request |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | AW | Word address |
| req_wdata_i | input | DW | Write data |
| req_be_i | input | DW/8 | Byte-lane enables, active high |
| rd_valid_o | output | 1 | Read data valid pulse |
| rd_data_o | output | DW | Read data, disabled lanes zero |
| sram_addr_o | output | AW | SRAM address |
| sram_ce_no | output | 1 | SRAM chip select, active low |
| sram_we_no | output | 1 | SRAM write strobe, active low |
| sram_oe_no | output | 1 | SRAM output enable, active low |
| sram_be_no | output | DW/8 | SRAM byte-lane selects, active low |
| sram_dq_i | input | DW | Data bus from SRAM |
| sram_dq_o | output | DW | Data bus to SRAM |
| sram_dq_oe_o | output | 1 | Controller drives the data bus |

## Verification
The bench builds the controller with a 4 ns clock, an 8-bit address and a 200 ns power-up wait. These values give a 50-cycle lockout, a 3-cycle read strobe, a 4-cycle write strobe and a 2-cycle turnaround, so that every rounding rule produces a count other than one. The short lockout lets the whole wait be counted edge by edge. The split between undriven and driven cycles inside the write strobe becomes visible at the pins. The SRAM model returns correct data only from the third output-enable cycle, so a read captured too early shows up as wrong data.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_SETUP    = 3'd1,
    ST_RD_WAIT  = 3'd2,
    ST_WR_PULSE = 3'd3,
    ST_RECOVER  = 3'd4
  } sram_state_e;

  // ceil(t / clk) with a floor of one cycle
  function automatic int unsigned cyc_of(int unsigned t_ps, int unsigned clk_ps);
    int unsigned c;
    c = (t_ps + clk_ps - 1) / clk_ps;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_pwrup_timer.sv
module sram_pwrup_timer #(
  parameter int unsigned PWR_CYC = 10000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic done_o
);
  localparam int unsigned CW = $clog2(PWR_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(PWR_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      cnt_q  <= cnt_q + 1'b1;
      done_q <= (cnt_q == LAST);
    end
  end

  assign done_o = done_q;

  // R1
  pwr_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> done_q);

endmodule

// File: rtl/sram_phase_cnt.sv
module sram_phase_cnt #(
  parameter int unsigned CW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i)            cnt_q <= '0;
    else if (cnt_q != '1)      cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/sram_access_fsm.sv
module sram_access_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned AW     = 20,
  parameter int unsigned DW     = 16,
  parameter int unsigned RD_CYC = 1,
  parameter int unsigned WP_CYC = 2,
  parameter int unsigned HZ_CYC = 1,
  parameter int unsigned CW     = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pwr_ok_i,
  input  logic [CW-1:0]   cnt_i,
  output logic            cnt_clr_o,
  input  logic            req_valid_i,
  output logic            req_ready_o,
  input  logic            req_we_i,
  input  logic [AW-1:0]   req_addr_i,
  input  logic [DW-1:0]   req_wdata_i,
  input  logic [DW/8-1:0] req_be_i,
  output logic            rd_valid_o,
  output logic [DW-1:0]   rd_data_o,
  output logic [AW-1:0]   sram_addr_o,
  output logic            sram_ce_no,
  output logic            sram_we_no,
  output logic            sram_oe_no,
  output logic [DW/8-1:0] sram_be_no,
  input  logic [DW-1:0]   sram_dq_i,
  output logic [DW-1:0]   sram_dq_o,
  output logic            sram_dq_oe_o
);
  localparam int unsigned LANES = DW / 8;
  localparam logic [CW-1:0] RD_LAST = CW'(RD_CYC - 1);
  localparam logic [CW-1:0] WP_LAST = CW'(WP_CYC - 1);
  localparam logic [CW-1:0] HZ_CNT  = CW'(HZ_CYC);

  sram_state_e state_q, state_d;
  logic             lat_we_q;
  logic [AW-1:0]    lat_addr_q;
  logic [DW-1:0]    lat_wdata_q;
  logic [LANES-1:0] lat_be_q;
  logic [DW-1:0]    lane_mask;
  logic [DW-1:0]    rd_data_q;
  logic             rd_valid_q;
  logic             accept, rd_last, sel_active;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_mask[g*8 +: 8] = {8{lat_be_q[g]}};
  end

  assign req_ready_o = (state_q == ST_IDLE) && pwr_ok_i;
  assign accept      = req_valid_i && req_ready_o;
  assign rd_last     = (state_q == ST_RD_WAIT) && (cnt_i == RD_LAST);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (accept) state_d = ST_SETUP;
      ST_SETUP:    state_d = lat_we_q ? ST_WR_PULSE : ST_RD_WAIT;
      ST_RD_WAIT:  if (cnt_i == RD_LAST) state_d = ST_RECOVER;
      ST_WR_PULSE: if (cnt_i == WP_LAST) state_d = ST_RECOVER;
      ST_RECOVER:  state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  assign cnt_clr_o = (state_d != state_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      lat_we_q    <= 1'b0;
      lat_addr_q  <= '0;
      lat_wdata_q <= '0;
      lat_be_q    <= '0;
      rd_data_q   <= '0;
      rd_valid_q  <= 1'b0;
    end else begin
      state_q    <= state_d;
      rd_valid_q <= rd_last;
      if (accept) begin
        lat_we_q    <= req_we_i;
        lat_addr_q  <= req_addr_i;
        lat_wdata_q <= req_wdata_i;
        lat_be_q    <= req_be_i;
      end
      if (rd_last) rd_data_q <= sram_dq_i & lane_mask;
    end
  end

  assign sel_active   = (state_q == ST_SETUP) || (state_q == ST_RD_WAIT) ||
                        (state_q == ST_WR_PULSE);
  assign sram_addr_o  = lat_addr_q;
  assign sram_ce_no   = !sel_active;
  assign sram_be_no   = sel_active ? ~lat_be_q : '1;
  assign sram_we_no   = (state_q != ST_WR_PULSE);
  assign sram_oe_no   = (state_q != ST_RD_WAIT);
  assign sram_dq_o    = lat_wdata_q;
  // drive only after the SRAM has released the bus, keep through recovery for hold
  assign sram_dq_oe_o = ((state_q == ST_WR_PULSE) && (cnt_i >= HZ_CNT)) ||
                        ((state_q == ST_RECOVER) && lat_we_q);
  assign rd_valid_o   = rd_valid_q;
  assign rd_data_o    = rd_data_q;

  // R5
  bus_contention_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sram_dq_oe_o && !sram_oe_no));
  // R4
  we_in_select_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_no |-> !sram_ce_no);
  // R7
  rd_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |=> !rd_valid_o);
  // R1
  lockout_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_ok_i |-> (sram_ce_no && !req_ready_o));
  // R9
  addr_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_ce_no && $past(!sram_ce_no)) |-> $stable(sram_addr_o));
  // R8
  ready_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (sram_ce_no && sram_we_no && sram_oe_no));

endmodule

// File: rtl/sram_access_ctrl.sv
module sram_access_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned AW         = 20,
  parameter int unsigned DW         = 16,
  parameter int unsigned CLK_PS     = 10000,
  parameter int unsigned T_PWRUP_PS = 100000000,
  parameter int unsigned T_RC_PS    = 10000,
  parameter int unsigned T_AA_PS    = 10000,
  parameter int unsigned T_DOE_PS   = 5000,
  parameter int unsigned T_WC_PS    = 10000,
  parameter int unsigned T_PWE_PS   = 7000,
  parameter int unsigned T_SCE_PS   = 7000,
  parameter int unsigned T_AW_PS    = 7000,
  parameter int unsigned T_SD_PS    = 5000,
  parameter int unsigned T_HZWE_PS  = 5000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  output logic            req_ready_o,
  input  logic            req_we_i,
  input  logic [AW-1:0]   req_addr_i,
  input  logic [DW-1:0]   req_wdata_i,
  input  logic [DW/8-1:0] req_be_i,
  output logic            rd_valid_o,
  output logic [DW-1:0]   rd_data_o,
  output logic [AW-1:0]   sram_addr_o,
  output logic            sram_ce_no,
  output logic            sram_we_no,
  output logic            sram_oe_no,
  output logic [DW/8-1:0] sram_be_no,
  input  logic [DW-1:0]   sram_dq_i,
  output logic [DW-1:0]   sram_dq_o,
  output logic            sram_dq_oe_o
);
  localparam int unsigned PWR_CYC = cyc_of(T_PWRUP_PS, CLK_PS);
  localparam int unsigned RD_CYC  = max2(cyc_of(T_RC_PS, CLK_PS),
                                    max2(cyc_of(T_AA_PS, CLK_PS), cyc_of(T_DOE_PS, CLK_PS)));
  localparam int unsigned HZ_CYC  = cyc_of(T_HZWE_PS, CLK_PS);
  localparam int unsigned WP_CYC  = max2(max2(cyc_of(T_WC_PS, CLK_PS), cyc_of(T_PWE_PS, CLK_PS)),
                                    max2(max2(cyc_of(T_SCE_PS, CLK_PS), cyc_of(T_AW_PS, CLK_PS)),
                                         HZ_CYC + cyc_of(T_SD_PS, CLK_PS)));
  localparam int unsigned CW      = $clog2(max2(RD_CYC, WP_CYC) + 1);

  logic          pwr_ok;
  logic          cnt_clr;
  logic [CW-1:0] cnt;

  sram_pwrup_timer #(.PWR_CYC(PWR_CYC)) i_pwrup (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .done_o (pwr_ok)
  );

  sram_phase_cnt #(.CW(CW)) i_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .cnt_o  (cnt)
  );

  sram_access_fsm #(
    .AW(AW), .DW(DW), .RD_CYC(RD_CYC), .WP_CYC(WP_CYC), .HZ_CYC(HZ_CYC), .CW(CW)
  ) i_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pwr_ok_i     (pwr_ok),
    .cnt_i        (cnt),
    .cnt_clr_o    (cnt_clr),
    .req_valid_i  (req_valid_i),
    .req_ready_o  (req_ready_o),
    .req_we_i     (req_we_i),
    .req_addr_i   (req_addr_i),
    .req_wdata_i  (req_wdata_i),
    .req_be_i     (req_be_i),
    .rd_valid_o   (rd_valid_o),
    .rd_data_o    (rd_data_o),
    .sram_addr_o  (sram_addr_o),
    .sram_ce_no   (sram_ce_no),
    .sram_we_no   (sram_we_no),
    .sram_oe_no   (sram_oe_no),
    .sram_be_no   (sram_be_no),
    .sram_dq_i    (sram_dq_i),
    .sram_dq_o    (sram_dq_o),
    .sram_dq_oe_o (sram_dq_oe_o)
  );

endmodule

// File: tb/test_sram_access_ctrl.sv
`timescale 1ns/1ps
module test_sram_access_ctrl;
  localparam int CLK_PERIOD = 4;
  localparam int AW = 8;
  localparam int DW = 16;
  // expected counts from the requirements at 4 ns clock:
  // power-up 200 ns -> 50, read max(10,10,5 ns) -> 3, write max(10,7,7,7, 5+5 ns -> 2+2) -> 4, turnaround 5 ns -> 2
  localparam int E_PWR = 50;
  localparam int E_RD  = 3;
  localparam int E_WP  = 4;
  localparam int E_HZ  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [1:0] req_be = '0;
  logic req_ready, rd_valid, ce_n, we_n, oe_n, dq_oe;
  logic [DW-1:0] rd_data, dq_o;
  logic [DW-1:0] dq_i = 16'hDEAD;
  logic [AW-1:0] sram_addr;
  logic [1:0] be_n;

  int checks = 0, errors = 0;
  bit done = 0;

  sram_access_ctrl #(
    .AW(AW), .DW(DW), .CLK_PS(4000), .T_PWRUP_PS(200000)
  ) i_sram_access_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_be_i(req_be),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .sram_addr_o(sram_addr), .sram_ce_no(ce_n), .sram_we_no(we_n),
    .sram_oe_no(oe_n), .sram_be_no(be_n),
    .sram_dq_i(dq_i), .sram_dq_o(dq_o), .sram_dq_oe_o(dq_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // SRAM model and pin monitor, evaluated away from the active edge
  logic [DW-1:0] mem [256];
  int oe_run = 0, we_run = 0;
  int oe_low_n = 0, we_low_n = 0, drv_early_n = 0, drv_in_pulse_n = 0;
  int contention_n = 0, addr_err_n = 0, ce_low_n = 0;
  bit pend = 0;
  logic [DW-1:0] pend_data;
  logic [1:0] pend_be;
  logic [AW-1:0] pend_addr, last_addr;
  logic last_ce_n = 1'b1;

  initial for (int i = 0; i < 256; i++) mem[i] = '0;

  always @(negedge clk) begin
    if (!ce_n) ce_low_n++;
    if (!ce_n && !last_ce_n && sram_addr != last_addr) addr_err_n++;
    last_ce_n = ce_n;
    last_addr = sram_addr;
    if (dq_oe && !oe_n) contention_n++;
    if (!ce_n && !oe_n && we_n) begin
      oe_run++; oe_low_n++;
    end else oe_run = 0;
    if (oe_run >= E_RD) begin
      dq_i[7:0]  = !be_n[0] ? mem[sram_addr][7:0]  : 8'hEE;
      dq_i[15:8] = !be_n[1] ? mem[sram_addr][15:8] : 8'hEE;
    end else dq_i = 16'hDEAD;
    if (!we_n && !ce_n) begin
      we_run++; we_low_n++;
      if (dq_oe) begin
        drv_in_pulse_n++;
        if (we_run <= E_HZ) drv_early_n++;
      end
      pend = 1; pend_data = dq_oe ? dq_o : 16'hxxxx;
      pend_be = ~be_n; pend_addr = sram_addr;
    end else begin
      we_run = 0;
      if (pend) begin
        if (pend_be[0]) mem[pend_addr][7:0]  = pend_data[7:0];
        if (pend_be[1]) mem[pend_addr][15:8] = pend_data[15:8];
        pend = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clr_stats();
    oe_low_n = 0; we_low_n = 0; drv_early_n = 0; drv_in_pulse_n = 0;
    contention_n = 0; addr_err_n = 0; ce_low_n = 0;
  endtask

  task automatic wait_ready();
    for (int g = 0; g < 1000 && !req_ready; g++) @(negedge clk);
  endtask

  // issues one request, returns cycles ready stayed low and rd_valid info
  task automatic access(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic [1:0] be, output int busy, output int vcnt,
                        output int vpos, output logic [DW-1:0] vdata);
    wait_ready();
    clr_stats();
    req_valid = 1; req_we = we; req_addr = a; req_wdata = d; req_be = be;
    @(negedge clk);
    req_valid = 0; req_wdata = ~d;
    busy = 1; vcnt = 0; vpos = 0; vdata = '0;
    for (int k = 1; k < 100; k++) begin
      @(negedge clk);
      if (rd_valid) begin vcnt++; vpos = k; vdata = rd_data; end
      if (req_ready) break;
      busy++;
    end
  endtask

  task automatic t_reset();
    #1;
    chk(ce_n && we_n && oe_n, "R2 strobes idle in reset", {ce_n, we_n, oe_n}, 3'b111);
    chk(be_n == 2'b11, "R2 byte selects idle", be_n, 2'b11);
    chk(!dq_oe && !rd_valid, "R2 bus and valid low", {dq_oe, rd_valid}, 0);
  endtask

  task automatic t_powerup();
    int n = 0;
    @(negedge clk);
    rst_n = 1;
    req_valid = 1; req_we = 0; req_addr = 8'h10; req_be = 2'b11;
    clr_stats();
    while (!req_ready && n < 1000) begin
      @(negedge clk);
      n++;
    end
    req_valid = 0;
    chk(n == E_PWR, "R1 lockout length", n, E_PWR);
    chk(ce_low_n == 0, "R1 no access during lockout", ce_low_n, 0);
    @(negedge clk);
    chk(ce_n && req_ready, "R1 request during lockout not taken", {ce_n, req_ready}, 2'b11);
  endtask

  task automatic t_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [1:0] be);
    int busy, vc, vp;
    logic [DW-1:0] vd;
    access(1, a, d, be, busy, vc, vp, vd);
    chk(busy == E_WP + 2, "R8 write busy length", busy, E_WP + 2);
    chk(we_low_n == E_WP, "R4 write strobe width", we_low_n, E_WP);
    chk(drv_early_n == 0, "R5 no drive in turnaround", drv_early_n, 0);
    chk(drv_in_pulse_n == E_WP - E_HZ, "R5 driven cycles in strobe", drv_in_pulse_n, E_WP - E_HZ);
    chk(vc == 0, "R7 no valid on write", vc, 0);
    chk(addr_err_n == 0, "R9 address stable", addr_err_n, 0);
  endtask

  task automatic t_read(input logic [AW-1:0] a, input logic [1:0] be, input logic [DW-1:0] exp);
    int busy, vc, vp;
    logic [DW-1:0] vd;
    access(0, a, '0, be, busy, vc, vp, vd);
    chk(busy == E_RD + 2, "R8 read busy length", busy, E_RD + 2);
    chk(oe_low_n == E_RD, "R3 read strobe width", oe_low_n, E_RD);
    chk(vc == 1, "R7 single valid pulse", vc, 1);
    chk(vp == E_RD + 1, "R7 valid position", vp, E_RD + 1);
    chk(vd == exp, "R7 R6 read data", vd, exp);
    chk(contention_n == 0, "R5 no drive while SRAM outputs", contention_n, 0);
    chk(addr_err_n == 0, "R9 address stable", addr_err_n, 0);
  endtask

  task automatic t_lanes();
    t_write(8'h21, 16'hA5C3, 2'b11);
    t_read (8'h21, 2'b11, 16'hA5C3);
    t_write(8'h21, 16'h1177, 2'b01);            // R6 low lane only
    t_read (8'h21, 2'b11, 16'hA577);
    t_write(8'h21, 16'h4400, 2'b10);            // R6 high lane only
    t_read (8'h21, 2'b11, 16'h4477);
    t_write(8'h22, 16'hFFFF, 2'b00);            // R6 no lane: nothing stored
    t_read (8'h22, 2'b11, 16'h0000);
    t_read (8'h21, 2'b01, 16'h0077);            // R7 disabled lane reads zero
    t_read (8'h21, 2'b10, 16'h4400);
  endtask

  task automatic t_patterns();
    for (int i = 0; i < 6; i++)
      t_write(AW'(8'h40 + i), DW'(16'h0101 * (i + 1) ^ 16'h8421), 2'b11);
    for (int i = 5; i >= 0; i--)
      t_read(AW'(8'h40 + i), 2'b11, DW'(16'h0101 * (i + 1) ^ 16'h8421));
  endtask

  initial begin
    t_reset();
    t_powerup();
    t_lanes();
    t_patterns();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule